// File: doc/BRIEF.md
# Leveled Timer Interrupt Control Register

This block is a single byte-wide control and status register that sits between one periodic timer and a prioritized interrupt handler. Each one-cycle pulse on the timer event input sets a sticky pending flag. The flag stays set until software clears it by writing a one to a self-clearing strobe bit. Two fields held in the register decide whether the pending flag turns into a request, and at which level: an enable bit and a 3-bit level selector. Level 0 means the source never raises a request.

The register is reached through a simple synchronous byte bus with an address, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. The request level output is registered too. It changes on the same clock edge as the register state that drives it, so the handler never sees a level that disagrees with the stored fields.

Top module: `tirq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable, level and pending state are 0. The outputs rdata, irq_pend and irq_lvl are also 0.
- R2: A tick pulse sets the pending flag at the next clock edge, whatever the enable setting. The flag then stays 1 until it is cleared.
- R3: A write to the register with wdata bit 3 set clears the pending flag. A write with bit 3 clear leaves the flag unchanged.
- R4: When a tick and a clearing write fall in the same cycle, the pending flag ends up 1.
- R5: A write stores wdata bit 4 as the enable and wdata bits 2..0 as the level. Written values on bits 7, 6 and 5 have no effect: in particular, writing bit 7 does not set the pending flag.
- R6: A read strobe to the register returns, one cycle later on rdata, the state held before that edge. The layout is: bit 7 pending, bit 4 enable, bits 2..0 level, and bits 6, 5 and 3 read 0. In a cycle after no read, rdata is 0.
- R7: irq_lvl equals the level field when the enable is 1, the flag is pending and the level is nonzero; otherwise irq_lvl is 0. It updates on the same edge as the state it reflects.
- R8: A read or write whose address differs from REG_ADDR changes no state and returns 0 on rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Bus byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| tick | input | 1 | One-cycle timer event pulse |
| rdata | output | 8 | Registered read data |
| irq_pend | output | 1 | Pending flag |
| irq_lvl | output | 3 | Active interrupt request level, 0 when no request |

## Verification
The bench builds the block with a 4-bit address and REG_ADDR set to 10. This keeps the address space small, so random traffic lands on foreign addresses often enough to exercise the decode (R8) while still mostly hitting the register. Because all eight level codes and both enable values are reachable from random write data, every gating combination of enable, pending and level is reached, including level 0 with a pending and enabled source. Directed cases force a tick and a clearing write into the same cycle, and a write of bit 7 while the flag is idle.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int DATA_W  = 8;
  localparam int LVL_W   = 3;
  localparam int PEND_BIT = 7;
  localparam int EN_BIT   = 4;
  localparam int CLR_BIT  = 3;
  localparam int LVL_LSB  = 0;

  // Assemble the readable image of the register from its live fields.
  function automatic logic [DATA_W-1:0] pack_view(input logic pend,
                                                  input logic en,
                                                  input logic [LVL_W-1:0] lvl);
    logic [DATA_W-1:0] v;
    v = '0;
    v[PEND_BIT] = pend;
    v[EN_BIT]   = en;
    v[LVL_LSB +: LVL_W] = lvl;
    return v;
  endfunction
endpackage

// File: rtl/tirq_cfg.sv
module tirq_cfg
  import tirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             en_in,
  input  logic [LVL_W-1:0] lvl_in,
  output logic             en_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic             en_d,
  output logic [LVL_W-1:0] lvl_d
);
  always_comb begin
    en_d  = en_q;
    lvl_d = lvl_q;
    if (wr_hit) begin
      en_d  = en_in;
      lvl_d = lvl_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      lvl_q <= '0;
    end else begin
      en_q  <= en_d;
      lvl_q <= lvl_d;
    end
  end

  // R5: a register write lands in the enable and level fields
  p_store_r5: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (en_q == $past(en_in)) && (lvl_q == $past(lvl_in)));
  p_keep_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(en_q) && $stable(lvl_q));
endmodule

// File: rtl/tirq_pend.sv
module tirq_pend (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr_req,
  output logic pend_q,
  output logic pend_d
);
  // A tick outranks a clear so a same-cycle event is not lost.
  always_comb begin
    if (tick)         pend_d = 1'b1;
    else if (clr_req) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> pend_q);
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_req) |=> pend_q);
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !tick) |=> !pend_q);
  p_no_spont_r5: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !tick) |=> !pend_q);
endmodule

// File: rtl/tirq_req.sv
module tirq_req
  import tirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_d,
  input  logic             pend_d,
  input  logic [LVL_W-1:0] lvl_d,
  output logic [LVL_W-1:0] irq_lvl
);
  logic live;
  assign live = en_d && pend_d && (lvl_d != '0);

  always_ff @(posedge clk) begin
    if (rst)       irq_lvl <= '0;
    else if (live) irq_lvl <= lvl_d;
    else           irq_lvl <= '0;
  end
endmodule

// File: rtl/tirq_ctrl.sv
module tirq_ctrl
  import tirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h1A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_pend,
  output logic [LVL_W-1:0]  irq_lvl
);
  logic hit, wr_hit, rd_hit, clr_req;
  logic en_q, en_d, pend_q, pend_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic unused_wbits;

  assign hit     = (addr == REG_ADDR);
  assign wr_hit  = wr_en && hit;
  assign rd_hit  = rd_en && hit;
  assign clr_req = wr_hit && wdata[CLR_BIT];
  assign unused_wbits = ^wdata[DATA_W-1:EN_BIT+1];

  tirq_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_hit(wr_hit),
    .en_in(wdata[EN_BIT]), .lvl_in(wdata[LVL_LSB +: LVL_W]),
    .en_q(en_q), .lvl_q(lvl_q), .en_d(en_d), .lvl_d(lvl_d)
  );

  tirq_pend u_pend (
    .clk(clk), .rst(rst), .tick(tick), .clr_req(clr_req),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  tirq_req u_req (
    .clk(clk), .rst(rst), .en_d(en_d), .pend_d(pend_d), .lvl_d(lvl_d),
    .irq_lvl(irq_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= pack_view(pend_q, en_q, lvl_q);
    else             rdata <= '0;
  end

  assign irq_pend = pend_q;

  // R7: any request seen downstream matches the stored, enabled, pending fields
  p_req_gated_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_lvl != '0) |-> (pend_q && en_q && (irq_lvl == lvl_q)));
  p_req_live_r7: assert property (@(posedge clk) disable iff (rst)
    (pend_q && en_q) |-> (irq_lvl == lvl_q));
  // R8: foreign writes leave the fields alone
  p_foreign_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit && !tick) |=> $stable(en_q) && $stable(lvl_q) && $stable(pend_q));
  // R6: no read strobe, no read data
  p_idle_read_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (rdata == '0));
endmodule

// File: tb/sim_tirq_ctrl.sv
module sim_tirq_ctrl;
  localparam int AW = 4;
  localparam logic [AW-1:0] RA = 4'd10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_pend;
  logic [2:0] irq_lvl;

  int n_chk = 0, n_bad = 0;
  bit m_pend = 0, m_en = 0;
  logic [2:0] m_lvl = '0;
  logic [7:0] m_rd = '0;

  always #2 clk = ~clk;

  tirq_ctrl #(.ADDR_W(AW), .REG_ADDR(RA)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .tick(tick), .rdata(rdata), .irq_pend(irq_pend),
    .irq_lvl(irq_lvl)
  );

  function automatic logic [2:0] exp_lvl(bit p, bit e, logic [2:0] l);
    return (p && e && l != 0) ? l : 3'd0;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " rdata"}, rdata, m_rd);
    chk({tag, " irq_pend"}, {7'd0, irq_pend}, {7'd0, m_pend});
    chk({tag, " irq_lvl"}, {5'd0, irq_lvl}, {5'd0, exp_lvl(m_pend, m_en, m_lvl)});
  endtask

  // Apply one cycle of bus/tick input, update the model, check at negedge.
  task automatic step(string tag, logic [AW-1:0] a, bit w, bit r,
                      logic [7:0] d, bit t);
    bit hit;
    addr = a; wr_en = w; rd_en = r; wdata = d; tick = t;
    @(posedge clk);
    hit = (a == RA);
    m_rd = (r && hit) ? {m_pend, 2'b00, m_en, 1'b0, m_lvl} : 8'd0;
    if (t) m_pend = 1;
    else if (w && hit && d[3]) m_pend = 0;
    if (w && hit) begin
      m_en = d[4];
      m_lvl = d[2:0];
    end
    @(negedge clk);
    check_all(tag);
    wr_en = 0; rd_en = 0; tick = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst = 0;
    @(negedge clk);
    check_all("R1 after reset");
    step("R1 read reset value", RA, 0, 1, 8'h00, 0);

    step("R2 tick with enable 0", RA, 0, 0, 8'h00, 1);
    step("R2 pending sticks", RA, 0, 1, 8'h00, 0);
    step("R3 write clear bit 0 keeps pending", RA, 1, 0, 8'h15, 0);
    step("R7 request at level 5", RA, 0, 1, 8'h00, 0);
    step("R6 clear bit reads 0", RA, 1, 0, 8'h1D, 0);
    step("R3 write one clears", RA, 0, 1, 8'h00, 0);
    step("R7 level 0 setup", RA, 1, 0, 8'h10, 0);
    step("R7 level 0 suppresses", RA, 0, 0, 8'h00, 1);
    step("R4 tick beats clear", RA, 1, 0, 8'h1F, 1);
    step("R4 read after tie", RA, 0, 1, 8'h00, 0);
    step("R5 clear for bit7 test", RA, 1, 0, 8'h0B, 0);
    step("R5 bit7 write ignored", RA, 1, 0, 8'hE2, 0);
    step("R5 read back", RA, 0, 1, 8'h00, 0);
    step("R8 foreign write", RA ^ 4'd1, 1, 0, 8'h1F, 0);
    step("R8 foreign read", RA ^ 4'd3, 0, 1, 8'h00, 0);
    step("R6 read no strobe", RA, 0, 0, 8'h00, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 4 != 0) ? RA : AW'($urandom);
      step("R7 random", a, ($urandom % 3) == 0, ($urandom % 2) == 0,
           8'($urandom), ($urandom % 5) == 0);
    end

    rst = 1;
    @(posedge clk);
    m_pend = 0; m_en = 0; m_lvl = 0; m_rd = 0;
    @(negedge clk);
    check_all("R1 second reset");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule